// File: doc/BRIEF.md
# I2C Register-Pair Write Controller

This block is the write side of an I2C target whose configuration space is a bank of eight-bit registers grouped in pairs. A separate bus front end turns the SCL/SDA wires into single-cycle events: a start (or repeated start), a stop, and a received byte. The controller matches the address byte against a strapped seven-bit target address and takes the first byte after a matching write address as a command. That command points at a register. It then returns an acknowledge decision for every byte that belongs to it.

Each data byte that follows is written to the pointed register. After each data byte the pointer moves to the other register of the same pair, so a transfer of any length keeps alternating between the two halves of one pair and never reaches another pair. Every accepted write comes out as a one-cycle strobe with the register index and the data value, for capture by an external register file. The map holds 22 registers at indices 0 to 21. The pairs sit at even/odd indices (2k, 2k+1). Pair 0 (indices 0 and 1, the input port) and pair 10 (indices 20 and 21, the interrupt status) are read-only.

Top module: `i2c_pair_wr_ctrl`

## Requirements
- R1: After a start, the next byte is the address byte. It is acknowledged (ack_vld=1, ack=1) when bits 7:1 equal strap_addr. Otherwise it is answered with ack_vld=1, ack=0, and every byte up to the next start produces no ack_vld and no wr_stb.
- R2: A matching address byte with bit 0 = 1 (read) is acknowledged, but no byte up to the next start produces ack_vld or wr_stb.
- R3: The first byte after a matching address with bit 0 = 0 is the command byte. It is acknowledged and produces no wr_stb.
- R4: Each later data byte is acknowledged. It produces wr_stb with wr_idx equal to the pointer, and then bit 0 of the pointer is inverted. After command C the strobes go to C, C^1, C, C^1, ... for any number of bytes.
- R5: A command value of 22 or above is acknowledged, and the data bytes after it are acknowledged but produce no wr_stb.
- R6: Data bytes aimed at indices 0, 1, 20 or 21 are acknowledged but produce no wr_stb.
- R7: A stop or a repeated start ends the transfer. After a new start and matching write address, the first byte is again a command byte, and no data byte is written before it.
- R8: ack_vld and ack appear in the cycle after the byte event. When a write happens, wr_stb is high for exactly that one cycle, with wr_data equal to the received byte.
- R9: After reset all outputs are 0, and bytes received before any start produce no ack_vld and no wr_stb.
- R10: A byte event in the same cycle as a start or stop is ignored, and the start or stop takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 7 | Seven-bit target address from straps |
| ev_start | input | 1 | Start or repeated start seen (one cycle) |
| ev_stop | input | 1 | Stop seen (one cycle) |
| ev_byte_vld | input | 1 | A byte has been received (one cycle) |
| ev_byte | input | 8 | Received byte value |
| ack_vld | output | 1 | An acknowledge decision is presented |
| ack | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| wr_stb | output | 1 | Register write strobe |
| wr_idx | output | 5 | Register index being written |
| wr_data | output | 8 | Data to write |

## Verification
The bench goes after long data runs. A design that auto-increments instead of toggling bit 0 writes to C+2 or to a neighbouring pair on the third byte. Commands on odd indices, out-of-range values such as 22, 23 and 255, and the read-only indices are all driven; a design that gates writes wrongly strobes where the index is invalid or protected. Repeated starts with no stop between them, read addresses, mismatched addresses, bytes that arrive with no start before them, and bytes that arrive together with a start or stop are mixed into random traffic. A design that keeps a stale command, keeps writing after a boundary, or acknowledges foreign traffic then shows an unexpected ack_vld or wr_stb.

// File: rtl/i2c_pw_pkg.sv
package i2c_pw_pkg;
  localparam int NUM_PAIRS = 11;
  localparam int NUM_REGS  = 2 * NUM_PAIRS;
  localparam int IDX_W     = $clog2(NUM_REGS);
  localparam int ADDR_W    = 7;
  localparam int BYTE_W    = 8;
  // pair numbers that hold read-only registers
  localparam int RO_PAIR_A = 0;
  localparam int RO_PAIR_B = NUM_PAIRS - 1;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_CMD  = 3'd2,
    ST_DATA = 3'd3,
    ST_SKIP = 3'd4
  } seq_st_e;

  function automatic logic reg_is_ro(input logic [BYTE_W-1:0] idx);
    return (idx[BYTE_W-1:1] == (BYTE_W-1)'(RO_PAIR_A)) ||
           (idx[BYTE_W-1:1] == (BYTE_W-1)'(RO_PAIR_B));
  endfunction

  function automatic logic reg_in_map(input logic [BYTE_W-1:0] idx);
    return {24'd0, idx} < 32'(NUM_REGS);
  endfunction
endpackage

// File: rtl/i2c_pw_seq.sv
module i2c_pw_seq
  import i2c_pw_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] strap_addr,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_byte_vld,
  input  logic [BW-1:0] ev_byte,
  output logic          cmd_take,
  output logic          data_take,
  output logic          ack_vld,
  output logic          ack
);
  seq_st_e st_q, st_n;
  logic    ack_vld_n, ack_n;
  logic    addr_hit;

  assign addr_hit = (ev_byte[BW-1:1] == strap_addr);

  always_comb begin
    st_n      = st_q;
    cmd_take  = 1'b0;
    data_take = 1'b0;
    ack_vld_n = 1'b0;
    ack_n     = 1'b0;
    if (ev_start) begin
      st_n = ST_ADDR;
    end else if (ev_stop) begin
      st_n = ST_IDLE;
    end else if (ev_byte_vld) begin
      unique case (st_q)
        ST_ADDR: begin
          ack_vld_n = 1'b1;
          if (addr_hit) begin
            ack_n = 1'b1;
            st_n  = ev_byte[0] ? ST_SKIP : ST_CMD;
          end else begin
            st_n  = ST_SKIP;
          end
        end
        ST_CMD: begin
          ack_vld_n = 1'b1;
          ack_n     = 1'b1;
          cmd_take  = 1'b1;
          st_n      = ST_DATA;
        end
        ST_DATA: begin
          ack_vld_n = 1'b1;
          ack_n     = 1'b1;
          data_take = 1'b1;
        end
        default: begin
          st_n = st_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ack_vld <= 1'b0;
      ack     <= 1'b0;
    end else begin
      st_q    <= st_n;
      ack_vld <= ack_vld_n;
      ack     <= ack_n;
    end
  end
endmodule

// File: rtl/i2c_pw_ptr.sv
module i2c_pw_ptr
  import i2c_pw_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_take,
  input  logic          data_take,
  input  logic [BW-1:0] byte_in,
  output logic [BW-1:0] ptr,
  output logic          ptr_ok
);
  logic [BW-1:0] ptr_n;
  logic          ok_n;
  logic          ptr_en;

  assign ptr_en = cmd_take | data_take;

  always_comb begin
    ptr_n = ptr;
    ok_n  = ptr_ok;
    if (cmd_take) begin
      ptr_n = byte_in;
      ok_n  = reg_in_map(byte_in);
    end else if (data_take) begin
      ptr_n = {ptr[BW-1:1], ~ptr[0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      ptr_ok <= 1'b0;
    end else if (ptr_en) begin
      ptr    <= ptr_n;
      ptr_ok <= ok_n;
    end
  end
endmodule

// File: rtl/i2c_pw_gate.sv
module i2c_pw_gate
  import i2c_pw_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_take,
  input  logic [BW-1:0] ptr,
  input  logic          ptr_ok,
  input  logic [BW-1:0] byte_in,
  output logic          wr_stb,
  output logic [IW-1:0] wr_idx,
  output logic [BW-1:0] wr_data
);
  logic stb_n;

  assign stb_n = data_take & ptr_ok & ~reg_is_ro(ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb <= 1'b0;
    end else begin
      wr_stb <= stb_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx  <= '0;
      wr_data <= '0;
    end else if (stb_n) begin
      wr_idx  <= ptr[IW-1:0];
      wr_data <= byte_in;
    end
  end
endmodule

// File: rtl/i2c_pair_wr_ctrl.sv
module i2c_pair_wr_ctrl
  import i2c_pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] strap_addr,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_byte_vld,
  input  logic [BYTE_W-1:0] ev_byte,
  output logic              ack_vld,
  output logic              ack,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  logic              cmd_take, data_take;
  logic [BYTE_W-1:0] ptr;
  logic              ptr_ok;

  i2c_pw_seq #(.AW(ADDR_W), .BW(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_byte_vld(ev_byte_vld), .ev_byte(ev_byte),
    .cmd_take(cmd_take), .data_take(data_take),
    .ack_vld(ack_vld), .ack(ack)
  );

  i2c_pw_ptr #(.BW(BYTE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .cmd_take(cmd_take),
    .data_take(data_take), .byte_in(ev_byte),
    .ptr(ptr), .ptr_ok(ptr_ok)
  );

  i2c_pw_gate #(.BW(BYTE_W), .IW(IDX_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .data_take(data_take),
    .ptr(ptr), .ptr_ok(ptr_ok), .byte_in(ev_byte),
    .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
  );
endmodule

// File: rtl/i2c_pw_chk.sv
module i2c_pw_chk
  import i2c_pw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ev_start,
  input logic              ev_stop,
  input logic              ev_byte_vld,
  input logic [BYTE_W-1:0] ev_byte,
  input logic              ack_vld,
  input logic              ack,
  input logic              wr_stb,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [BYTE_W-1:0] wr_data
);
  logic             last_vld;
  logic [IDX_W-1:0] last_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_vld <= 1'b0;
      last_idx <= '0;
    end else if (ev_start | ev_stop) begin
      last_vld <= 1'b0;
    end else if (wr_stb) begin
      last_vld <= 1'b1;
      last_idx <= wr_idx;
    end
  end

  p_ack_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld |-> $past(ev_byte_vld & ~ev_start & ~ev_stop));
  p_stb_acked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (ack_vld && ack));
  p_stb_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_data == $past(ev_byte)));
  p_idx_in_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> reg_in_map(BYTE_W'(wr_idx)));
  p_no_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !reg_is_ro(BYTE_W'(wr_idx)));
  p_pair_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && last_vld) |-> (wr_idx == {last_idx[IDX_W-1:1], ~last_idx[0]}));
endmodule

bind i2c_pair_wr_ctrl i2c_pw_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_byte_vld(ev_byte_vld), .ev_byte(ev_byte), .ack_vld(ack_vld),
  .ack(ack), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/i2c_pair_wr_ctrl_tb.sv
module i2c_pair_wr_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] strap_addr = 7'h74;
  logic       ev_start = 1'b0, ev_stop = 1'b0, ev_byte_vld = 1'b0;
  logic [7:0] ev_byte = 8'h00;
  logic       ack_vld, ack, wr_stb;
  logic [4:0] wr_idx;
  logic [7:0] wr_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  // bench model: 0 idle, 1 addr, 2 cmd, 3 data, 4 skip
  int mst = 0;
  int mptr = 0;
  bit mok = 0;

  always #2 clk = ~clk;

  i2c_pair_wr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_byte_vld(ev_byte_vld),
    .ev_byte(ev_byte), .ack_vld(ack_vld), .ack(ack), .wr_stb(wr_stb),
    .wr_idx(wr_idx), .wr_data(wr_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit ro_idx(int i);
    return (i == 0) || (i == 1) || (i == 20) || (i == 21);
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // packs {ack_vld, ack, wr_stb, idx, data} with idx/data masked when no strobe
  function automatic logic [15:0] pack(bit av, bit ak, bit sb, int idx, int dat);
    logic [15:0] v;
    v = {av, ak, sb, sb ? 5'(idx) : 5'd0, sb ? 8'(dat) : 8'd0};
    return v;
  endfunction

  task automatic cyc_check(string tag, bit e_av, bit e_ak, bit e_sb, int e_idx, int e_dat);
    @(negedge clk);
    ev_start = 0; ev_stop = 0; ev_byte_vld = 0;
    chk(tag, pack(ack_vld, ack, wr_stb, int'(wr_idx), int'(wr_data)),
        pack(e_av, e_ak, e_sb, e_idx, e_dat));
  endtask

  task automatic send_byte(string tag, logic [7:0] b);
    bit e_av, e_ak, e_sb;
    int e_idx;
    e_av = 0; e_ak = 0; e_sb = 0; e_idx = 0;
    case (mst)
      1: begin
        e_av = 1;
        if (b[7:1] == strap_addr) begin e_ak = 1; mst = b[0] ? 4 : 2; end
        else mst = 4;
      end
      2: begin e_av = 1; e_ak = 1; mptr = int'(b); mok = (b < 8'd22); mst = 3; end
      3: begin
        e_av = 1; e_ak = 1;
        e_sb = mok && !ro_idx(mptr);
        e_idx = mptr;
        mptr = mptr ^ 1;
      end
      default: ;
    endcase
    @(negedge clk);
    ev_byte_vld = 1; ev_byte = b;
    cyc_check(tag, e_av, e_ak, e_sb, e_idx, int'(b));
  endtask

  task automatic send_evt(string tag, bit st, bit sp, bit with_byte, logic [7:0] b);
    @(negedge clk);
    ev_start = st; ev_stop = sp; ev_byte_vld = with_byte; ev_byte = b;
    mst = st ? 1 : 0;
    cyc_check(tag, 0, 0, 0, 0, 0);
  endtask

  task automatic wr_run(string tag, logic [7:0] cmd, int n);
    send_evt(tag, 1, 0, 0, 8'h00);
    send_byte(tag, {strap_addr, 1'b0});
    send_byte(tag, cmd);
    for (int i = 0; i < n; i++) send_byte(tag, 8'($urandom));
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk("R9 reset", pack(ack_vld, ack, wr_stb, 0, 0) | {3'b0, wr_idx, wr_data}, 16'h0000);
    rst_n = 1;
    send_byte("R9 byte before start", 8'hE8);
    send_byte("R9 byte before start", 8'h03);
    // R4 long run on odd command
    wr_run("R4", 8'd3, 9);
    send_evt("R7 stop", 0, 1, 0, 8'h00);
    wr_run("R4 even", 8'd6, 5);
    // R7 repeated start without stop: first byte must be a command again
    wr_run("R7 restart", 8'd9, 3);
    send_evt("R7 stop", 0, 1, 0, 8'h00);
    send_byte("R7 after stop", 8'h55);
    // R5 out of range commands
    wr_run("R5", 8'd22, 3);
    wr_run("R5", 8'd23, 2);
    wr_run("R5", 8'd255, 3);
    // R6 read-only pairs
    wr_run("R6", 8'd0, 3);
    wr_run("R6", 8'd21, 3);
    wr_run("R4 top writable", 8'd19, 3);
    // R1 mismatch
    send_evt("R1", 1, 0, 0, 8'h00);
    send_byte("R1 mismatch", {strap_addr ^ 7'h01, 1'b0});
    send_byte("R1 ignored", 8'h04);
    send_byte("R1 ignored", 8'h11);
    // R2 read
    send_evt("R2", 1, 0, 0, 8'h00);
    send_byte("R2 read addr", {strap_addr, 1'b1});
    send_byte("R2 ignored", 8'h04);
    send_byte("R2 ignored", 8'h22);
    // R3 command alone then stop
    wr_run("R3", 8'd4, 0);
    send_evt("R3 stop", 0, 1, 0, 8'h00);
    // R10 byte together with start/stop
    send_evt("R10 start+byte", 1, 0, 1, {strap_addr, 1'b0});
    send_byte("R10 addr after", {strap_addr, 1'b0});
    send_byte("R10 cmd", 8'd2);
    send_byte("R10 data", 8'hA5);
    send_evt("R10 stop+byte", 0, 1, 1, 8'h3C);
    send_byte("R10 after stop", 8'h3C);
    // random traffic
    for (int t = 0; t < 400; t++) begin
      int kind;
      int n;
      kind = int'($urandom % 8);
      n = int'($urandom % 7);
      send_evt("R7 rnd", 1, 0, 0, 8'h00);
      if (kind == 0)
        send_byte("R1 rnd", {strap_addr ^ 7'(1 + $urandom % 127), 1'($urandom)});
      else if (kind == 1)
        send_byte("R2 rnd", {strap_addr, 1'b1});
      else begin
        send_byte("R1 rnd", {strap_addr, 1'b0});
        send_byte("R3 rnd", 8'($urandom % 26));
      end
      for (int i = 0; i < n; i++) send_byte("R4 rnd", 8'($urandom));
      if ($urandom % 2 == 0) send_evt("R7 rnd stop", 0, 1, 0, 8'h00);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule